// File: doc/BRIEF.md
# RNS Channel Residue Combiner

This block forms one channel of the final residue in a sum-of-residues modular multiplier that works in a residue number system. Each cycle it can accept a full set of partial products for its channel, one from each contribution, plus a small correction index. The partial products are added as plain integers in carry-save form. No modulus is applied between additions, so the sum word is a few bits wider than a term. In the same stage the index selects a stored correction value. That value is the channel residue of the negated multiple of the dynamic range, reduced by the large modulus. The correction is then added to the sum. A single Barrett step reduces the total into the range below the channel modulus.

The channel modulus and its Barrett constant are inputs, so one module serves every channel of a multiplier. The correction table is a per-instance parameter. An optional register stage splits the term sum and table read from the final add and reduction. An index outside the table raises an error flag that travels with the result.

Top module: `rns_chan_combiner`

## Requirements
- R1: While rst_n is low and after its release, before any accepted input, out_valid, residue_out and alpha_err are all 0.
- R2: For every accepted input, residue_out equals (sum of all N_TERMS terms + CORR_TBL entry selected by alpha_in) mod modulus_in. The result is fully reduced, below modulus_in. Term j occupies terms_in[j*TERM_W +: TERM_W] and table entry k occupies CORR_TBL[k*TERM_W +: TERM_W].
- R3: With PIPE=1, out_valid is high exactly 2 cycles after the edge that accepts in_valid and low after 1 cycle. With PIPE=0 the latency is 1 cycle.
- R4: The term sum is never wrapped. With all terms at 2^TERM_W-1 and the largest correction, the result is still exact (sum width TERM_W+clog2(N_TERMS+1) bits, 21 at defaults).
- R5: Every index from 0 to N_TERMS-1 selects its own table entry k, and that entry is the value added.
- R6: An alpha_in of N_TERMS or more gives alpha_err=1 with that result, and the result is computed with a correction of zero. A legal index gives alpha_err=0.
- R7: Without in_valid, residue_out and alpha_err hold their last values and out_valid goes low, whatever the data inputs do.
- R8: modulus_in must lie strictly between 2^(MOD_W-1) and 2^MOD_W. barrett_k_in must be floor(2^SUM_W / modulus_in). Under those conditions a term sum of 446438 with correction 13693 and modulus 16183 yields 7007.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Accept the terms and index this cycle |
| terms_in | input | N_TERMS*TERM_W | Packed partial-product terms for this channel |
| alpha_in | input | AW | Correction table index |
| modulus_in | input | MOD_W | Channel modulus |
| barrett_k_in | input | KW | floor(2^SUM_W / modulus) |
| out_valid | output | 1 | residue_out and alpha_err are new this cycle |
| residue_out | output | MOD_W | Reduced channel residue |
| alpha_err | output | 1 | Index was out of range for this result |

## Verification
The worked example sum checks the fixed known answer, and a sweep over every legal index with fixed terms shows that each table entry is picked distinctly. All-maximum terms combined with the top index stress the widest sum, so any wrap of the accumulator or an under-reduction in the Barrett step shows up. Random terms under several moduli, including one near the lower bound where the Barrett constant is largest, separate a correct single conditional subtraction from an off-by-one quotient. Out-of-range indices, idle cycles with toggling data, and latency probes cover the error flag, hold behaviour and timing.

// File: rtl/rns_comb_pkg.sv
package rns_comb_pkg;
  localparam int DEF_N  = 40;
  localparam int DEF_TW = 15;
  localparam int DEF_M  = 16183;

  // default correction contents: a deterministic spread of residues below DEF_M
  function automatic logic [DEF_N*DEF_TW-1:0] default_tbl();
    logic [DEF_N*DEF_TW-1:0] v;
    v = '0;
    for (int k = 0; k < DEF_N; k++) begin
      v[k*DEF_TW +: DEF_TW] = DEF_TW'((13693 + k * 3571) % DEF_M);
    end
    return v;
  endfunction
endpackage

// File: rtl/csa_sum.sv
module csa_sum #(
  parameter int NUM = 40,
  parameter int IW  = 15,
  parameter int OW  = 21
) (
  input  logic [NUM*IW-1:0] ops,
  output logic [OW-1:0]     total
);
  logic [OW-1:0] ps [NUM];
  logic [OW-1:0] pc [NUM];

  assign ps[0] = OW'(ops[0 +: IW]);
  assign pc[0] = '0;

  // carry-save chain: each stage folds one operand without carry propagation
  for (genvar k = 1; k < NUM; k++) begin : g_csa
    logic [OW-1:0] x;
    assign x     = OW'(ops[k*IW +: IW]);
    assign ps[k] = ps[k-1] ^ pc[k-1] ^ x;
    assign pc[k] = ((ps[k-1] & pc[k-1]) | (ps[k-1] & x) | (pc[k-1] & x)) << 1;
  end

  assign total = ps[NUM-1] + pc[NUM-1];
endmodule

// File: rtl/corr_rom.sv
module corr_rom #(
  parameter int N_TERMS = 40,
  parameter int TERM_W  = 15,
  parameter int AW      = 6,
  parameter logic [N_TERMS*TERM_W-1:0] TBL = '0
) (
  input  logic [AW-1:0]     idx,
  output logic [TERM_W-1:0] corr,
  output logic              bad_idx
);
  logic [TERM_W-1:0] tbl_w [N_TERMS];

  for (genvar k = 0; k < N_TERMS; k++) begin : g_unpack
    assign tbl_w[k] = TBL[k*TERM_W +: TERM_W];
  end

  always_comb begin
    bad_idx = (32'(idx) >= N_TERMS);
    corr    = '0;
    for (int k = 0; k < N_TERMS; k++) begin
      if (idx == AW'(k)) corr = tbl_w[k];
    end
  end
endmodule

// File: rtl/barrett_fold.sv
module barrett_fold #(
  parameter int SUM_W = 21,
  parameter int MOD_W = 14,
  parameter int KW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic [SUM_W-1:0] c_in,
  input  logic [MOD_W-1:0] m_in,
  input  logic [KW-1:0]    k_in,
  output logic [MOD_W-1:0] r_out
);
  localparam int PW = SUM_W + KW;

  logic [PW-1:0]    prod;
  logic [KW-1:0]    q_est;
  logic [SUM_W-1:0] qm;
  logic [SUM_W-1:0] diff;
  logic [MOD_W:0]   r1;

  always_comb begin
    prod  = PW'(c_in) * PW'(k_in);
    q_est = prod[PW-1:SUM_W];
    qm    = SUM_W'(SUM_W'(q_est) * SUM_W'(m_in));
    diff  = c_in - qm;
    r1    = diff[MOD_W:0];
    if (r1 >= {1'b0, m_in}) r_out = MOD_W'(r1 - {1'b0, m_in});
    else                    r_out = r1[MOD_W-1:0];
  end

  // R2
  reduced_lt_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (r_out < m_in));
endmodule

// File: rtl/rns_chan_combiner.sv
module rns_chan_combiner #(
  parameter int N_TERMS = rns_comb_pkg::DEF_N,
  parameter int TERM_W  = rns_comb_pkg::DEF_TW,
  parameter int MOD_W   = 14,
  parameter bit PIPE    = 1'b1,
  parameter logic [N_TERMS*TERM_W-1:0] CORR_TBL = rns_comb_pkg::default_tbl(),
  localparam int SUM_W  = TERM_W + $clog2(N_TERMS + 1),
  localparam int KW     = SUM_W - MOD_W + 1,
  localparam int AW     = $clog2(N_TERMS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [N_TERMS*TERM_W-1:0] terms_in,
  input  logic [AW-1:0]             alpha_in,
  input  logic [MOD_W-1:0]          modulus_in,
  input  logic [KW-1:0]             barrett_k_in,
  output logic                      out_valid,
  output logic [MOD_W-1:0]          residue_out,
  output logic                      alpha_err
);
  logic [SUM_W-1:0]  tsum;
  logic [TERM_W-1:0] corr;
  logic              bad;

  csa_sum #(.NUM(N_TERMS), .IW(TERM_W), .OW(SUM_W)) u_sum (
    .ops   (terms_in),
    .total (tsum)
  );

  corr_rom #(.N_TERMS(N_TERMS), .TERM_W(TERM_W), .AW(AW), .TBL(CORR_TBL)) u_rom (
    .idx     (alpha_in),
    .corr    (corr),
    .bad_idx (bad)
  );

  // stage 1: term sum and table word side by side
  logic              s1_valid;
  logic [SUM_W-1:0]  s1_sum;
  logic [TERM_W-1:0] s1_corr;
  logic              s1_bad;

  if (PIPE) begin : g_pipe
    logic              v_q;
    logic [SUM_W-1:0]  sum_q;
    logic [TERM_W-1:0] corr_q;
    logic              bad_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum_q  <= '0;
        corr_q <= '0;
        bad_q  <= 1'b0;
      end else if (in_valid) begin
        sum_q  <= tsum;
        corr_q <= corr;
        bad_q  <= bad;
      end
    end

    assign s1_valid = v_q;
    assign s1_sum   = sum_q;
    assign s1_corr  = corr_q;
    assign s1_bad   = bad_q;
  end else begin : g_flat
    assign s1_valid = in_valid;
    assign s1_sum   = tsum;
    assign s1_corr  = corr;
    assign s1_bad   = bad;
  end

  // stage 2: add correction, single reduction
  logic [SUM_W-1:0] total;
  logic [MOD_W-1:0] red;

  assign total = s1_sum + SUM_W'(s1_corr);

  barrett_fold #(.SUM_W(SUM_W), .MOD_W(MOD_W), .KW(KW)) u_red (
    .clk    (clk),
    .rst_n  (rst_n),
    .chk_en (s1_valid),
    .c_in   (total),
    .m_in   (modulus_in),
    .k_in   (barrett_k_in),
    .r_out  (red)
  );

  logic             ov_d;
  logic [MOD_W-1:0] res_d;
  logic             err_d;

  always_comb begin
    ov_d  = s1_valid;
    res_d = residue_out;
    err_d = alpha_err;
    if (s1_valid) begin
      res_d = red;
      err_d = s1_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      residue_out <= '0;
      alpha_err   <= 1'b0;
    end else begin
      out_valid   <= ov_d;
      residue_out <= res_d;
      alpha_err   <= err_d;
    end
  end

  // R3
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##(1 + PIPE) out_valid);

  // R6
  bad_alpha_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (32'(alpha_in) >= N_TERMS)) |-> ##(1 + PIPE) alpha_err);

  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> ($stable(residue_out) && $stable(alpha_err) && !out_valid));
endmodule

// File: tb/sim_rns_chan_combiner.sv
module sim_rns_chan_combiner;
  localparam int N  = 40;
  localparam int TW = 15;
  localparam int MW = 14;
  localparam int SW = 21;
  localparam int KW = 8;
  localparam int AW = 6;

  function automatic logic [N*TW-1:0] mk_tbl();
    logic [N*TW-1:0] v;
    v = '0;
    for (int k = 0; k < N; k++) v[k*TW +: TW] = TW'((13693 + k * 3571) % 16183);
    return v;
  endfunction
  localparam logic [N*TW-1:0] TBL = mk_tbl();

  logic clk, rst_n, in_valid, out_valid, alpha_err;
  logic [N*TW-1:0] terms_in;
  logic [AW-1:0]   alpha_in;
  logic [MW-1:0]   modulus_in, residue_out;
  logic [KW-1:0]   barrett_k_in;

  int checks = 0, fails = 0;
  bit done = 0;

  rns_chan_combiner #(.N_TERMS(N), .TERM_W(TW), .MOD_W(MW), .PIPE(1'b1), .CORR_TBL(TBL)) u0 (
    .clk, .rst_n, .in_valid, .terms_in, .alpha_in, .modulus_in, .barrett_k_in,
    .out_valid, .residue_out, .alpha_err
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint tbl_at(int a);
    return (a < N) ? longint'((13693 + a * 3571) % 16183) : 0;
  endfunction

  function automatic longint expect_res(logic [N*TW-1:0] t, int a, int m);
    longint s = 0;
    for (int j = 0; j < N; j++) s += longint'(t[j*TW +: TW]);
    return (s + tbl_at(a)) % m;
  endfunction

  task automatic set_mod(int m);
    modulus_in   = MW'(m);
    barrett_k_in = KW'((1 << SW) / m);
  endtask

  // one operation: drive at negedge, probe 1 and 2 cycles later
  task automatic run_op(string req, logic [N*TW-1:0] t, int a, int m);
    set_mod(m);
    terms_in = t; alpha_in = AW'(a); in_valid = 1;
    @(negedge clk);
    in_valid = 0;
    chk({req, " R3 early"}, out_valid, 0);
    @(negedge clk);
    chk({req, " R3 valid"}, out_valid, 1);
    chk(req, residue_out, expect_res(t, a, m));
    chk({req, " R6 flag"}, alpha_err, (a >= N) ? 1 : 0);
  endtask

  task automatic t_reset();
    rst_n = 0; in_valid = 0; terms_in = '1; alpha_in = '0; set_mod(16183);
    repeat (3) @(negedge clk);
    chk("R1 valid", out_valid, 0);
    chk("R1 residue", residue_out, 0);
    chk("R1 err", alpha_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", out_valid, 0);
  endtask

  task automatic t_example();
    logic [N*TW-1:0] t = '0;
    for (int j = 0; j < 13; j++) t[j*TW +: TW] = TW'(32767);
    t[13*TW +: TW] = TW'(20467);
    run_op("R8 example", t, 0, 16183);
    chk("R8 value 7007", residue_out, 7007);
  endtask

  task automatic t_alpha_sweep();
    logic [N*TW-1:0] t = '0;
    for (int j = 0; j < N; j++) t[j*TW +: TW] = TW'(j * 701 + 5);
    for (int a = 0; a < N; a++) run_op("R5 alpha sweep", t, a, 16183);
  endtask

  task automatic t_all_max();
    run_op("R4 all max", '1, N - 1, 16183);
    run_op("R4 all max low mod", '1, N - 1, 8209);
    run_op("R4 all max top mod", '1, 0, 16381);
  endtask

  task automatic t_random();
    int mods[4] = '{16183, 16319, 8209, 16381};
    for (int i = 0; i < 24; i++) begin
      logic [N*TW-1:0] t;
      for (int j = 0; j < N; j++) t[j*TW +: TW] = TW'($urandom());
      run_op("R2 random", t, int'($urandom_range(0, N - 1)), mods[i % 4]);
    end
  endtask

  task automatic t_bad_alpha();
    logic [N*TW-1:0] t = '0;
    for (int j = 0; j < N; j++) t[j*TW +: TW] = TW'(j * 97);
    run_op("R6 alpha 40", t, 40, 16183);
    run_op("R6 alpha 63", t, 63, 16319);
    run_op("R6 legal clears", t, 3, 16183);
  endtask

  task automatic t_hold();
    logic [MW-1:0] keep;
    logic keep_e;
    run_op("R7 setup", '1, 45, 16183);
    keep = residue_out; keep_e = alpha_err;
    for (int i = 0; i < 5; i++) begin
      terms_in = {N{TW'($urandom())}}; alpha_in = AW'(i); set_mod(8209 + i);
      @(negedge clk);
      chk("R7 residue held", residue_out, keep);
      chk("R7 err held", alpha_err, keep_e);
      chk("R7 valid low", out_valid, 0);
    end
  endtask

  initial begin
    t_reset();
    t_example();
    t_alpha_sweep();
    t_all_max();
    t_random();
    t_bad_alpha();
    t_hold();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule